// File: doc/BRIEF.md
# Microport Bootload RAM Controller

This block sits behind an 8-bit processor port with a 6-bit address. It steers each access either to a bank of device registers or, during a bootload, into a program RAM. A small control register holds two bits. One selects where the program runs from (ROM or RAM). The other turns bootload mode on. The control register lives at address 0x3F.

While bootload is on, a write to any address other than 0x3F does three things:
- it places its byte at an internal, auto-incrementing RAM pointer;
- the pointer then steps on, wrapping at the RAM depth;
- the byte is folded into a 16-bit CRC signature.

Software can read back the signature's low byte to confirm the image. A read with the top address bit set returns the control register instead. Clearing the bootload bit rewinds the pointer and reseeds the signature, ready for the next load.

While bootload is off, every read and write is forwarded to the device register bank. A write to 0x3F is also captured by the control register, and a read of 0x3F returns the control register. The program-source and bootload bits are exposed as outputs.

Top module: `bootload_port`

## Requirements
- R1: After the active-low reset, run_from_ram_o and boot_mode_o are 0, rdata_o is 0x00, the RAM pointer is 0 and the signature is 0xFFFF.
- R2: A write to address 0x3F in either mode loads the control register: data bit 3 goes to run_from_ram_o and data bit 2 to boot_mode_o. Data bits 7:4 and 1:0 are dropped. The control readback byte is {4'b0000, run, boot, 2'b00}.
- R3: In bootload mode, a write to an address other than 0x3F pulses ram_we_o in that same cycle, with ram_addr_o equal to the pointer and ram_wdata_o equal to wdata_i. The pointer then advances by one.
- R4: After writing location RAM_DEPTH-1, the pointer wraps to 0.
- R5: In bootload mode, a write to 0x3F does not pulse ram_we_o, and leaves the pointer and the signature unchanged.
- R6: The signature is a CRC-16 with polynomial 0x1021 and seed 0xFFFF. Each bootload data byte is shifted in MSB first.
- R7: In bootload mode, a read with addr_i[5]=1 returns the control readback byte, and a read with addr_i[5]=0 returns the signature's low byte. Reads never write RAM or move the pointer.
- R8: With bootload off, each strobe pulses dreg_we_o or dreg_re_o, with dreg_addr_o equal to addr_i and dreg_wdata_o equal to wdata_i, for every address. Read data is dreg_rdata_i sampled in the strobe cycle, except that 0x3F returns the control readback byte. In this mode ram_we_o never pulses. In bootload mode the device register strobes never pulse.
- R9: While the bootload bit is 0, the pointer is held at 0 and the signature at 0xFFFF. A new bootload therefore starts at RAM location 0 with a fresh seed.
- R10: rdata_o changes only on the cycle after a read strobe and holds its value otherwise.
- R11: When a read and a write share a cycle, the read returns the state from before that write.
- R12: The encoding run=1 with boot=1 is legal: bootload proceeds normally while run_from_ram_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 6 | Port address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, valid the cycle after rd_i |
| ram_we_o | output | 1 | Program RAM write enable |
| ram_addr_o | output | PTR_W | Program RAM address (bootload pointer) |
| ram_wdata_o | output | 8 | Program RAM write data |
| dreg_we_o | output | 1 | Device register write strobe |
| dreg_re_o | output | 1 | Device register read strobe |
| dreg_addr_o | output | 6 | Device register address |
| dreg_wdata_o | output | 8 | Device register write data |
| dreg_rdata_i | input | 8 | Device register read data, combinational |
| run_from_ram_o | output | 1 | Program source: 0 ROM, 1 RAM |
| boot_mode_o | output | 1 | Bootload mode active |

## Verification
A bootload data write and a signature readback can land in the same cycle. The write advances the CRC at the clock edge, and that same edge captures the read data. The bench issues read and write strobes together on alternate bytes of a wrapping stream. It expects the signature byte from before that write, then confirms the updated value on the following read-only access. A control write paired with a control read is judged the same way: the old control byte must come back.

// File: rtl/bootload_pkg.sv
package bootload_pkg;
  localparam int unsigned PORT_AW  = 6;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SIG_W    = 16;
  localparam logic [SIG_W-1:0] SIG_SEED = 16'hFFFF;
  localparam logic [SIG_W-1:0] SIG_POLY = 16'h1021;
  localparam logic [PORT_AW-1:0] CTRL_ADDR = '1;

  typedef struct packed {
    logic run_ram;
    logic boot;
  } ctrl_t;

  function automatic logic [SIG_W-1:0] sig_fold(input logic [SIG_W-1:0] s,
                                                input logic [BYTE_W-1:0] b);
    logic [SIG_W-1:0] r;
    logic fb;
    r = s;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = r[SIG_W-1] ^ b[i];
      r  = {r[SIG_W-2:0], 1'b0} ^ (fb ? SIG_POLY : '0);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_byte(input ctrl_t c);
    return {4'b0000, c.run_ram, c.boot, 2'b00};
  endfunction
endpackage

// File: rtl/bootload_ctrl.sv
module bootload_ctrl
  import bootload_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  // reserved bits 1:0 and 7:4 are not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.run_ram <= wdata_i[3];
      ctrl_q.boot    <= wdata_i[2];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bootload_ptr.sv
module bootload_ptr #(
  parameter int unsigned RAM_DEPTH = 64,
  localparam int unsigned PTR_W    = $clog2(RAM_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);
  localparam bit POW2 = ((RAM_DEPTH & (RAM_DEPTH - 1)) == 0);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;

  generate
    if (POW2) begin : g_natural_wrap
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_compare_wrap
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (step_i)  ptr_q <= ptr_inc;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/bootload_sig.sv
module bootload_sig
  import bootload_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reseed_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [SIG_W-1:0]  sig_o
);
  logic [SIG_W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sig_q <= SIG_SEED;
    else if (reseed_i) sig_q <= SIG_SEED;
    else if (load_i)   sig_q <= sig_fold(sig_q, byte_i);
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/bootload_port.sv
module bootload_port
  import bootload_pkg::*;
#(
  parameter int unsigned RAM_DEPTH = 64,
  localparam int unsigned PTR_W    = $clog2(RAM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [PORT_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  output logic               ram_we_o,
  output logic [PTR_W-1:0]   ram_addr_o,
  output logic [BYTE_W-1:0]  ram_wdata_o,
  output logic               dreg_we_o,
  output logic               dreg_re_o,
  output logic [PORT_AW-1:0] dreg_addr_o,
  output logic [BYTE_W-1:0]  dreg_wdata_o,
  input  logic [BYTE_W-1:0]  dreg_rdata_i,
  output logic               run_from_ram_o,
  output logic               boot_mode_o
);
  ctrl_t             ctrl;
  logic              ctrl_hit;
  logic              ctrl_we;
  logic              load_we;
  logic [SIG_W-1:0]  sig_q;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q;

  assign ctrl_hit = (addr_i == CTRL_ADDR);
  assign ctrl_we  = wr_i & ctrl_hit;
  assign load_we  = wr_i & ctrl.boot & ~ctrl_hit;

  bootload_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  bootload_ptr #(.RAM_DEPTH(RAM_DEPTH)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (~ctrl.boot),
    .step_i  (load_we),
    .ptr_o   (ptr)
  );

  bootload_sig u_sig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reseed_i (~ctrl.boot),
    .load_i   (load_we),
    .byte_i   (wdata_i),
    .sig_o    (sig_q)
  );

  // bootload reads decode only the top address bit
  always_comb begin
    if (ctrl.boot)
      rd_mux = addr_i[PORT_AW-1] ? ctrl_byte(ctrl) : sig_q[BYTE_W-1:0];
    else
      rd_mux = ctrl_hit ? ctrl_byte(ctrl) : dreg_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o        = rdata_q;
  assign ram_we_o       = load_we;
  assign ram_addr_o     = ptr;
  assign ram_wdata_o    = wdata_i;
  assign dreg_we_o      = wr_i & ~ctrl.boot;
  assign dreg_re_o      = rd_i & ~ctrl.boot;
  assign dreg_addr_o    = addr_i;
  assign dreg_wdata_o   = wdata_i;
  assign run_from_ram_o = ctrl.run_ram;
  assign boot_mode_o    = ctrl.boot;
endmodule

// File: rtl/bootload_port_chk.sv
module bootload_port_chk #(
  parameter int unsigned RAM_DEPTH = 64,
  localparam int unsigned PTR_W    = $clog2(RAM_DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [5:0]       addr_i,
  input logic [7:0]       rdata_o,
  input logic             ram_we_o,
  input logic [PTR_W-1:0] ram_addr_o,
  input logic             dreg_we_o,
  input logic             dreg_re_o,
  input logic             boot_mode_o,
  input logic [15:0]      sig_q
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(RAM_DEPTH - 1);
  logic [PTR_W-1:0] exp_nxt;
  assign exp_nxt = (ram_addr_o == LAST) ? '0 : ram_addr_o + 1'b1;

  assert_ram_we_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (wr_i && boot_mode_o && addr_i != 6'h3F));

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (ram_addr_o == $past(exp_nxt)));

  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_mode_o && !ram_we_o) |=> (!boot_mode_o || ram_addr_o == $past(ram_addr_o)));

  assert_sig_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_mode_o && !ram_we_o) |=> (!boot_mode_o || sig_q == $past(sig_q)));

  assert_idle_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_mode_o |=> (ram_addr_o == '0 && sig_q == 16'hFFFF));

  assert_no_dreg_boot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_mode_o |-> (!dreg_we_o && !dreg_re_o));

  assert_no_ram_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_mode_o |-> !ram_we_o);

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind bootload_port bootload_port_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (.*);

// File: tb/bootload_port_bench.sv
module bootload_port_bench;
  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, ram_wdata, dreg_wdata, dreg_rdata;
  logic ram_we, dreg_we, dreg_re, run_ram, boot;
  logic [PW-1:0] ram_addr;
  logic [5:0] dreg_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  bit c3_m = 0, c2_m = 0;
  int ptr_m = 0;
  logic [15:0] sig_m = 16'hFFFF;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  assign dreg_rdata = {2'b10, dreg_addr} ^ 8'h5A;

  bootload_port #(.RAM_DEPTH(DEPTH)) u_bootload_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .dreg_we_o(dreg_we), .dreg_re_o(dreg_re),
    .dreg_addr_o(dreg_addr), .dreg_wdata_o(dreg_wdata), .dreg_rdata_i(dreg_rdata),
    .run_from_ram_o(run_ram), .boot_mode_o(boot)
  );

  function automatic logic [15:0] crc_step(input logic [15:0] s, input logic [7:0] b);
    logic [23:0] x;
    // polynomial long division of (s xor b<<8) shifted by eight zero bits
    x = {s ^ {b, 8'h00}, 8'h00};
    for (int i = 23; i >= 16; i--)
      if (x[i]) x[i-:17] = x[i-:17] ^ 17'h11021;
    return x[15:0];
  endfunction

  function automatic logic [7:0] cbyte();
    return {4'b0, c3_m, c2_m, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // call just after a rising edge
  task automatic op(input bit w, input bit r, input logic [5:0] a, input logic [7:0] d);
    logic [7:0] exp_rd;
    bit exp_rwe;
    if (c2_m) exp_rd = a[5] ? cbyte() : sig_m[7:0];
    else      exp_rd = (a == 6'h3F) ? cbyte() : ({2'b10, a} ^ 8'h5A);
    exp_rwe = w && c2_m && a != 6'h3F;
    wr = w; rd = r; addr = a; wdata = d;
    #2;
    if (w) begin
      chk(ram_we == exp_rwe, "R3/R5 ram_we", ram_we, exp_rwe);
      chk(dreg_we == !c2_m, "R8 dreg_we", dreg_we, !c2_m);
      if (exp_rwe) begin
        chk(ram_addr == PW'(ptr_m), "R3/R4 ram_addr", ram_addr, ptr_m);
        chk(ram_wdata == d, "R3 ram_wdata", ram_wdata, d);
      end
      if (!c2_m) chk(dreg_addr == a && dreg_wdata == d, "R8 dreg addr/data",
                     {dreg_addr, dreg_wdata}, {a, d});
    end
    if (r) begin
      chk(dreg_re == !c2_m, "R8 dreg_re", dreg_re, !c2_m);
      if (!w) chk(ram_we == 1'b0, "R7 read no ram write", ram_we, 0);
    end
    @(posedge clk); #1;
    wr = 0; rd = 0;
    // model update
    if (w) begin
      if (a == 6'h3F) begin
        c3_m = d[3]; c2_m = d[2];
        if (!c2_m) begin ptr_m = 0; sig_m = 16'hFFFF; end
      end else if (c2_m) begin
        sig_m = crc_step(sig_m, d);
        ptr_m = (ptr_m + 1) % DEPTH;
      end
    end
    if (r) begin
      chk(rdata == exp_rd, "R7/R8/R11 rdata", rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      chk(rdata == last_rd, "R10 rdata hold", rdata, last_rd);
    end
    chk({run_ram, boot} == {c3_m, c2_m}, "R2 ctrl outputs", {run_ram, boot}, {c3_m, c2_m});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #3;
    // R1 reset state
    chk(rdata == 8'h00 && !run_ram && !boot && ram_addr == '0 && !ram_we,
        "R1 reset", {rdata, run_ram, boot}, 0);
    #10 rst_n = 1'b1;
    @(posedge clk); #1;

    // R8 normal mode sweep, every address but the control one
    for (int a = 0; a < 63; a++) begin
      op(1, 0, 6'(a), 8'(a) ^ 8'h33);
      op(0, 1, 6'(a), 8'h00);
    end
    op(0, 1, 6'h3F, 8'h00);               // R2 control readback = 0

    // R2/R12 reserved bits dropped, both bits set
    op(1, 0, 6'h3F, 8'hFF);
    op(0, 1, 6'h3F, 8'h00);               // R7 top bit set -> 0x0C
    op(0, 1, 6'h20, 8'h00);
    op(1, 0, 6'h3F, 8'h04);
    op(0, 1, 6'h00, 8'h00);               // R9 seed low byte FF

    // R3/R4/R6/R11 stream with wrap; even bytes read sig in same cycle
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) op(1, 1, 6'(i % 32), 8'(i * 37 + 5));
      else begin
        op(1, 0, 6'(i % 63), 8'(i * 37 + 5));
        op(0, 1, 6'(i % 32), 8'h00);
      end
      if (i == 20) begin
        // R5 control write mid-stream keeps pointer and signature
        op(1, 0, 6'h3F, 8'hF4);
        op(0, 1, 6'h11, 8'h00);
        op(1, 1, 6'h3F, 8'h04);           // R11 control read/write together
        op(0, 1, 6'h25, 8'h00);
      end
    end

    // R9 clearing boot rewinds pointer and reseeds
    op(1, 0, 6'h3F, 8'h00);
    op(0, 1, 6'h3F, 8'h00);
    op(1, 0, 6'h3F, 8'h04);
    op(0, 1, 6'h01, 8'h00);
    op(1, 0, 6'h05, 8'hA7);
    op(0, 1, 6'h01, 8'h00);

    // R12 run from RAM while loading
    op(1, 0, 6'h3F, 8'h0C);
    for (int i = 0; i < 20; i++) begin
      op(1, 0, 6'(i + 2), 8'(255 - i * 11));
      op(0, 1, 6'h02, 8'h00);
    end

    // R1 reset mid-load
    rst_n = 1'b0; #2;
    chk(rdata == 8'h00 && !run_ram && !boot && ram_addr == '0,
        "R1 reset mid-load", {rdata, run_ram, boot, ram_addr}, 0);
    c3_m = 0; c2_m = 0; ptr_m = 0; sig_m = 16'hFFFF; last_rd = 8'h00;
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    op(1, 0, 6'h3F, 8'h04);
    op(0, 1, 6'h00, 8'h00);               // R1/R9 seed after reset

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule